// File: doc/BRIEF.md
# Lane Meta-Frame Encoder

This block is the per-lane transmit coding stage of a multi-lane serial packet link. It accepts 64-bit words, each tagged as control or data, from the upstream lane striper. It wraps them into repeating meta frames of `META_LEN` words. Each frame opens with a synchronization word, a scrambler-state word and a skip word, and closes with a diagnostic word that holds a CRC32 over the whole frame.

The skip word, the payload and the diagnostic word are scrambled with an additive 58-bit scrambler whose starting state is a per-lane parameter. Every word then becomes a 67-bit line word: two framing bits give the word type, and one inversion bit keeps the running disparity of the lane bounded. While an overhead word goes out, the input is stalled. When no input word is offered at a payload position, nothing is emitted that cycle.

Top module: `mf_lane_encoder`

## Requirements
- R1: Within each frame of META_LEN words, position 0 carries 64'h78F6_78F6_78F6_78F6, position 1 the scrambler-state word, position 2 carries 64'h1E1E_1E1E_1E1E_1E1E, and position META_LEN-1 carries the diagnostic word {32'h6400_0000, crc}. All other positions carry payload.
- R2: in_ready is high exactly when the next word to emit is at a payload position. If in_ready is high and in_valid is low, out_valid is low in the next cycle.
- R3: Line bits 65:64 are 2'b01 for a data payload word and 2'b10 for a control payload word or any overhead word.
- R4: The keystream is produced 64 bits per word, bit 63 first. Each step computes n = s[57]^s[38], outputs n and shifts n in at the bottom (polynomial x^58+x^39+1). The skip, payload and diagnostic words are XORed with the keystream, and the state advances only on those words. The sync and state words pass in clear. The state starts at LANE_SEED after reset.
- R5: The scrambler-state word is {6'b001010, s}, where s is the state that will scramble the following skip word.
- R6: The CRC field holds a CRC32 with polynomial 0x1EDC6F41, initial value 32'hFFFF_FFFF and no final XOR. It is computed MSB first over bits 63:0 of every unscrambled word of the frame, with the diagnostic word's CRC field taken as zero.
- R7: Let d be twice the number of ones in the scrambled bits 63:0, minus 64. Bit 66 is set, and bits 63:0 are sent inverted, exactly when d and the running disparity are both nonzero and have the same sign. The running disparity then adds the sent word's d.
- R8: The running disparity stays within -64 to +64.
- R9: During and right after reset, out_valid and in_ready are low.
- R10: Payload words come out one cycle after acceptance, in order, with data and control flag preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_ctrl | input | 1 | Input word is a control word |
| in_data | input | 64 | Input word |
| in_ready | output | 1 | Input accepted this cycle if valid |
| out_valid | output | 1 | Line word valid |
| out_word | output | 67 | Encoded line word |

## Verification
The bench decodes every line word with its own descrambler and CRC. It holds the state word against the state it has tracked itself, so a scrambler that advanced on the clear words, or failed to advance on the skip word, would fail right after the first frame. Input gaps at payload positions are exercised: a design that emitted filler there, or moved its position counter, would misplace the diagnostic word and break the CRC. Long runs of all-ones and all-zero payload stress the inversion rule. Any inverted sign or off-by-one in the disparity comparison shows up as a wrong bit 66 or an excursion past 64.

// File: rtl/mf_enc_pkg.sv
package mf_enc_pkg;
  localparam int WORD_W = 64;
  localparam int SCR_W  = 58;
  localparam int CRC_W  = 32;
  localparam logic [CRC_W-1:0]  CRC_POLY = 32'h1EDC_6F41;
  localparam logic [CRC_W-1:0]  CRC_INIT = 32'hFFFF_FFFF;
  localparam logic [WORD_W-1:0] SYNC_WORD = 64'h78F6_78F6_78F6_78F6;
  localparam logic [WORD_W-1:0] SKIP_WORD = 64'h1E1E_1E1E_1E1E_1E1E;
  localparam logic [5:0]        STATE_TAG = 6'b001010;
  localparam logic [31:0]       DIAG_TAG  = 32'h6400_0000;

  typedef enum logic [2:0] {
    K_SYNC  = 3'd0,
    K_STATE = 3'd1,
    K_SKIP  = 3'd2,
    K_PAY   = 3'd3,
    K_DIAG  = 3'd4
  } word_kind_e;
endpackage

// File: rtl/mf_seq.sv
module mf_seq
  import mf_enc_pkg::*;
#(
  parameter int META_LEN = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  output word_kind_e kind
);
  localparam int PW = $clog2(META_LEN);
  localparam logic [PW-1:0] LAST = PW'(META_LEN - 1);

  logic [PW-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (step) pos_d = (pos_q == LAST) ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  always_comb begin
    if      (pos_q == PW'(0)) kind = K_SYNC;
    else if (pos_q == PW'(1)) kind = K_STATE;
    else if (pos_q == PW'(2)) kind = K_SKIP;
    else if (pos_q == LAST)   kind = K_DIAG;
    else                      kind = K_PAY;
  end

  // R1: the frame always restarts with a sync word after the diagnostic word
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step && kind == K_DIAG) |=> kind == K_SYNC);
endmodule

// File: rtl/mf_scrambler.sv
module mf_scrambler
  import mf_enc_pkg::*;
#(
  parameter logic [SCR_W-1:0] LANE_SEED = 58'h2A5_F00D_1234_5678
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [SCR_W-1:0]  state,
  output logic [WORD_W-1:0] ks
);
  logic [SCR_W-1:0] st_q, st_d, st_adv;

  always_comb begin
    logic [SCR_W-1:0] s;
    logic n;
    s  = st_q;
    ks = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      n     = s[57] ^ s[38];
      ks[i] = n;
      s     = {s[56:0], n};
    end
    st_adv = s;
    st_d   = adv ? st_adv : st_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LANE_SEED;
    else        st_q <= st_d;
  end

  assign state = st_q;

  // R4: a nonzero seed never collapses to the all-zero lockup state
  p_state_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);
  // R4: the state holds when no scrambled word is sent
  p_state_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(st_q));
endmodule

// File: rtl/mf_crc32.sv
module mf_crc32
  import mf_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              last,
  input  logic [WORD_W-1:0] word,
  output logic [CRC_W-1:0]  crc_new
);
  logic [CRC_W-1:0] crc_q, crc_d;

  always_comb begin
    logic [CRC_W-1:0] c;
    logic fb;
    c = crc_q;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ word[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    crc_new = c;
    crc_d   = crc_q;
    if (en) crc_d = last ? CRC_INIT : c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_INIT;
    else        crc_q <= crc_d;
  end

  // R6: accumulation restarts for each frame
  p_crc_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && last) |=> crc_q == CRC_INIT);
endmodule

// File: rtl/mf_disparity.sv
module mf_disparity
  import mf_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [WORD_W-1:0] body,
  output logic              inv
);
  logic signed [7:0] rd_q, rd_d;

  always_comb begin
    int ones_i, d_i, rd_i, nx_i;
    ones_i = $countones(body);
    d_i    = 2 * ones_i - WORD_W;
    rd_i   = int'(rd_q);
    inv    = (rd_i > 0 && d_i > 0) || (rd_i < 0 && d_i < 0);
    nx_i   = inv ? rd_i - d_i : rd_i + d_i;
    rd_d   = en ? 8'(nx_i) : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  // R8: running disparity stays bounded
  p_rd_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q >= -8'sd64) && (rd_q <= 8'sd64));
endmodule

// File: rtl/mf_lane_encoder.sv
module mf_lane_encoder
  import mf_enc_pkg::*;
#(
  parameter int                META_LEN  = 2048,
  parameter logic [SCR_W-1:0]  LANE_SEED = 58'h2A5_F00D_1234_5678
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_ctrl,
  input  logic [WORD_W-1:0]   in_data,
  output logic                in_ready,
  output logic                out_valid,
  output logic [WORD_W+2:0]   out_word
);
  localparam int LINE_W = WORD_W + 3;

  word_kind_e        kind;
  logic              emit, scr_on, is_ctrl, inv;
  logic [SCR_W-1:0]  scr_state;
  logic [WORD_W-1:0] ks, content, full, body;
  logic [CRC_W-1:0]  crc_new;
  logic              ov_q, ov_d;
  logic [LINE_W-1:0] ow_q, ow_d;

  mf_seq #(.META_LEN(META_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .step(emit), .kind(kind)
  );

  mf_scrambler #(.LANE_SEED(LANE_SEED)) u_scr (
    .clk(clk), .rst_n(rst_n), .adv(emit && scr_on),
    .state(scr_state), .ks(ks)
  );

  mf_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .en(emit), .last(kind == K_DIAG),
    .word(content), .crc_new(crc_new)
  );

  mf_disparity u_disp (
    .clk(clk), .rst_n(rst_n), .en(emit), .body(body), .inv(inv)
  );

  always_comb begin
    in_ready = (kind == K_PAY);
    emit     = (kind != K_PAY) || in_valid;
    scr_on   = (kind == K_SKIP) || (kind == K_PAY) || (kind == K_DIAG);
    is_ctrl  = (kind != K_PAY) || in_ctrl;
    unique case (kind)
      K_SYNC:  content = SYNC_WORD;
      K_STATE: content = {STATE_TAG, scr_state};
      K_SKIP:  content = SKIP_WORD;
      K_DIAG:  content = {DIAG_TAG, {CRC_W{1'b0}}};
      default: content = in_data;
    endcase
    full = (kind == K_DIAG) ? (content | {{(WORD_W-CRC_W){1'b0}}, crc_new}) : content;
    body = scr_on ? (full ^ ks) : full;
    ov_d = emit;
    ow_d = ow_q;
    if (emit) ow_d = {inv, is_ctrl ? 2'b10 : 2'b01, inv ? ~body : body};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      ow_q <= '0;
    end else begin
      ov_q <= ov_d;
      ow_q <= ow_d;
    end
  end

  assign out_valid = ov_q;
  assign out_word  = ow_q;

  // R2: an empty payload slot produces no line word
  p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> !out_valid);
  // R3: an accepted data word is framed as data
  p_data_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid && !in_ctrl) |=> (out_valid && out_word[65:64] == 2'b01));
  // R1: the sync slot emits the sync pattern in clear (possibly inverted)
  p_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_SYNC) |=> (out_valid && out_word[65:64] == 2'b10 &&
      (out_word[63:0] == SYNC_WORD || out_word[63:0] == ~SYNC_WORD)));
endmodule

// File: tb/tb_mf_lane_encoder.sv
module tb_mf_lane_encoder;
  localparam int M = 16;
  localparam logic [57:0] SEED = 58'h1C3_9E37_79B9_7F4A;
  localparam logic [63:0] SYNC_W = 64'h78F6_78F6_78F6_78F6;
  localparam logic [63:0] SKIP_W = 64'h1E1E_1E1E_1E1E_1E1E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ctrl = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_ready, out_valid;
  logic [66:0] out_word;

  int total = 0, bad = 0;

  mf_lane_encoder #(.META_LEN(M), .LANE_SEED(SEED)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctrl(in_ctrl),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_word(out_word)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [66:0] act, input logic [66:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_ks(input logic [57:0] st);
    logic [57:0] s = st;
    logic [63:0] k;
    for (int i = 63; i >= 0; i--) begin
      k[i] = s[57] ^ s[38];
      s = {s[56:0], k[i]};
    end
    return k;
  endfunction

  function automatic logic [57:0] ref_adv(input logic [57:0] st);
    logic [57:0] s = st;
    logic n;
    for (int i = 0; i < 64; i++) begin
      n = s[57] ^ s[38];
      s = {s[56:0], n};
    end
    return s;
  endfunction

  function automatic logic [31:0] ref_crc(input logic [31:0] c0, input logic [63:0] w);
    logic [31:0] c = c0;
    logic fb;
    for (int i = 63; i >= 0; i--) begin
      fb = c[31] ^ w[i];
      c = {c[30:0], 1'b0} ^ (fb ? 32'h1EDC_6F41 : 32'h0);
    end
    return c;
  endfunction

  // monitor state
  logic [64:0] expq[$];
  int nxt = 0, rd = 0, frames = 0, crc_ok = 0;
  logic [57:0] bs;
  logic [31:0] bcrc = 32'hFFFF_FFFF;
  bit have_state = 0, stall_prev = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) chk(!out_valid, "R2", "word emitted in empty slot", 67'(out_valid), 67'(0));
      if (out_valid) begin
        logic [63:0] raw, plain;
        logic exp_inv;
        int d;
        raw = out_word[66] ? ~out_word[63:0] : out_word[63:0];
        d = 2 * $countones(raw) - 64;
        exp_inv = (rd > 0 && d > 0) || (rd < 0 && d < 0);
        chk(out_word[66] == exp_inv, "R7", "inversion bit", 67'(out_word[66]), 67'(exp_inv));
        rd = rd + (out_word[66] ? -d : d);
        chk(rd >= -64 && rd <= 64, "R8", "disparity bound", 67'(rd + 128), 67'(128));
        plain = raw;
        if (nxt >= 2) begin
          plain = raw ^ ref_ks(bs);
          bs = ref_adv(bs);
        end
        if (nxt == 0) begin
          chk(out_word[65:64] == 2'b10, "R3", "sync framing", 67'(out_word[65:64]), 67'(2));
          chk(plain == SYNC_W, "R1", "sync word", 67'(plain), 67'(SYNC_W));
          bcrc = ref_crc(32'hFFFF_FFFF, plain);
        end else if (nxt == 1) begin
          chk(out_word[65:64] == 2'b10, "R3", "state framing", 67'(out_word[65:64]), 67'(2));
          chk(plain[63:58] == 6'b001010, "R5", "state tag", 67'(plain[63:58]), 67'(6'b001010));
          if (!have_state)
            chk(plain[57:0] == SEED, "R4", "first state is seed", 67'(plain[57:0]), 67'(SEED));
          else
            chk(plain[57:0] == bs, "R4", "state advance", 67'(plain[57:0]), 67'(bs));
          bs = plain[57:0];
          have_state = 1;
          bcrc = ref_crc(bcrc, plain);
        end else if (nxt == 2) begin
          chk(plain == SKIP_W, "R1", "skip word", 67'(plain), 67'(SKIP_W));
          bcrc = ref_crc(bcrc, plain);
        end else if (nxt == M - 1) begin
          chk(plain[63:32] == 32'h6400_0000, "R1", "diag tag", 67'(plain[63:32]), 67'(32'h6400_0000));
          bcrc = ref_crc(bcrc, {plain[63:32], 32'h0});
          chk(plain[31:0] == bcrc, "R6", "frame crc", 67'(plain[31:0]), 67'(bcrc));
          if (plain[31:0] == bcrc) crc_ok++;
          frames++;
        end else begin
          logic [64:0] e;
          if (expq.size() == 0) begin
            chk(0, "R10", "unexpected payload", 67'(plain), 67'(0));
          end else begin
            e = expq.pop_front();
            chk(plain == e[63:0], "R10", "payload data", 67'(plain), 67'(e[63:0]));
            chk(out_word[65:64] == (e[64] ? 2'b10 : 2'b01), "R3", "payload framing",
                67'(out_word[65:64]), 67'(e[64] ? 2 : 1));
          end
          bcrc = ref_crc(bcrc, plain);
        end
        nxt = (nxt + 1) % M;
      end
      chk(in_ready == (nxt >= 3 && nxt < M - 1), "R2", "ready vs position",
          67'(in_ready), 67'(nxt >= 3 && nxt < M - 1));
      stall_prev = in_ready && !in_valid;
    end
  end

  // inputs change 2 ns after a rising edge
  task automatic send(input bit c, input logic [63:0] d);
    bit r;
    in_valid = 1'b1; in_ctrl = c; in_data = d;
    do begin
      @(negedge clk); r = in_ready;
      @(posedge clk);
      if (r) expq.push_back({c, d});
      #2;
    end while (!r);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 0, "R9", "out_valid in reset", 67'(out_valid), 67'(0));
    chk(in_ready == 0, "R9", "in_ready in reset", 67'(in_ready), 67'(0));
    @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0, "R9", "out_valid after reset", 67'(out_valid), 67'(0));
    chk(in_ready == 0, "R9", "in_ready after reset (sync slot)", 67'(in_ready), 67'(0));
    @(posedge clk); #2;
  endtask

  task automatic t_stream();
    for (int i = 0; i < 30; i++)
      send(i % 3 == 0, {32'(i), 32'hA5A5_0000 + 32'(i)});
    idle(2);
    chk(expq.size() == 0, "R10", "stream drained", 67'(expq.size()), 67'(0));
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 12; i++) begin
      send(i[0], 64'hDEAD_BEEF_0000_0000 | 64'(i));
      idle(1 + i % 3);
    end
    chk(expq.size() == 0, "R2", "gapped stream drained", 67'(expq.size()), 67'(0));
  endtask

  task automatic t_bias();
    for (int i = 0; i < 40; i++) send(1'b0, (i < 20) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0);
    idle(2);
    chk(expq.size() == 0, "R8", "biased stream drained", 67'(expq.size()), 67'(0));
  endtask

  task automatic t_close(input int want);
    int guard = 0;
    while (frames < want && guard < 2000) begin
      send(1'b0, 64'(guard) * 64'h9E37_79B9_7F4A_7C15);
      guard++;
    end
    idle(3);
    chk(frames >= want, "R1", "frames completed", 67'(frames), 67'(want));
    chk(crc_ok == frames, "R6", "all frame crcs good", 67'(crc_ok), 67'(frames));
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_stream();
        t_gaps();
        t_bias();
        t_close(10);
      end
      begin
        repeat (100000) @(posedge clk);
        chk(0, "WDOG", "watchdog expired", 67'(0), 67'(1));
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule